// File: doc/BRIEF.md
# CSR Access Executor

This block carries out the six control-and-status-register access instructions of a 32-bit RISC-V integer core against a small file of 32-bit registers that it holds itself. Each cycle in which `in_valid` is high, the instruction word and the value read from its source register are taken in. The block picks out the register address, the access kind and the source field. It reads the addressed register and works out the replacement value. On the same clock edge it commits the update and any write back to the destination register.

The register file holds `NUM_CSR` entries. Each entry answers to one 12-bit address taken from the parameter `CSR_ADDRS`, where entry i is `CSR_ADDRS[12*i +: 12]`. The destination-register port (`rd_we`, `rd_idx`, `rd_data`) is combinational from the inputs. The core's integer register file is expected to capture it on the same edge that updates the CSR. The block has no back-pressure: it accepts every cycle that `in_valid` is high, so there is no ready signal. A caller that must stall simply holds `in_valid` low.

Top module: `csr_exec_unit`

## Requirements
- R1: After reset every implemented register reads as zero.
- R2: The block acts only on words with bits 6:0 equal to 1110011 and bits 14:12 in {001, 010, 011, 101, 110, 111}. Any other word raises no destination write and changes no register.
- R3: Bits 14:12 = 001 (register write) stores `rs1_data` unconditionally into the register addressed by bits 31:20.
- R4: Bits 14:12 = 010 (set) stores old OR `rs1_data`, and 011 (clear) stores old AND NOT `rs1_data`. Either one writes only when the source index in bits 19:15 is nonzero. With index zero the register is left unchanged whatever `rs1_data` holds.
- R5: The immediate kinds (101 write, 110 set, 111 clear) use bits 19:15 zero-extended to 32 bits as the operand and ignore `rs1_data`. Immediate write always stores. Immediate set and clear store only when the 5-bit field is nonzero.
- R6: For a recognized word with valid high and destination index (bits 11:7) nonzero, `rd_we` is 1, `rd_idx` equals bits 11:7, and `rd_data` is the register value before this access's update.
- R7: With destination index zero, `rd_we` stays 0, but the register update still happens under the rules of R3 to R5.
- R8: An address that matches no entry reads as zero, so `rd_data` is 0. A write to such an address changes no implemented register.
- R9: While `in_valid` is low, `rd_we` is 0 and no register changes.
- R10: An update becomes visible to the very next access, including one issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| rs1_data | input | 32 | Value of the source register named by bits 19:15 |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Register value before the update |

## Verification
The hardest case to reach from the ports is an update that is suppressed while other inputs say otherwise. Examples are a set or clear with source index zero while `rs1_data` is all ones, or an immediate kind driven with a junk `rs1_data`. A wrong design that ignores the index would still look correct if `rs1_data` were zero. The bench therefore drives the inverse pattern in those cycles. It then proves the register kept its value by a follow-up set access with index zero, which reads without writing. Back-to-back accesses to one address check that a new value is seen in the next cycle.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;
  localparam int XLEN = 32;
  localparam logic [6:0] SYSTEM_OPCODE = 7'b1110011;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_SET   = 2'b10,
    ACC_CLEAR = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic        legal;
    acc_kind_e   kind;
    logic        use_imm;
    logic [4:0]  src;
    logic [4:0]  dst;
    logic [11:0] addr;
  } acc_dec_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_exec_pkg::*;
(
  input  logic [31:0] insn,
  output acc_dec_t    dec
);
  logic [2:0] f3;
  logic       op_hit;

  always_comb begin
    f3          = insn[14:12];
    op_hit      = (insn[6:0] == SYSTEM_OPCODE);
    dec.kind    = acc_kind_e'(f3[1:0]);
    dec.use_imm = f3[2];
    dec.legal   = op_hit && (f3[1:0] != 2'b00);
    dec.src     = insn[19:15];
    dec.dst     = insn[11:7];
    dec.addr    = insn[31:20];
  end
endmodule

// File: rtl/csr_update.sv
module csr_update
  import csr_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  acc_kind_e    kind,
  input  logic         src_nz,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] operand,
  output logic [W-1:0] new_val,
  output logic         store
);
  always_comb begin
    unique case (kind)
      ACC_WRITE: begin new_val = operand;            store = 1'b1;   end
      ACC_SET:   begin new_val = old_val | operand;  store = src_nz; end
      ACC_CLEAR: begin new_val = old_val & ~operand; store = src_nz; end
      default:   begin new_val = old_val;            store = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
  parameter int                   NUM_CSR   = 4,
  parameter int                   W         = 32,
  parameter logic [NUM_CSR*12-1:0] ADDR_LIST = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          addr,
  input  logic                 wr_en,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         rd_val,
  output logic [NUM_CSR*W-1:0] state_flat
);
  logic [NUM_CSR-1:0] hit;
  logic [W-1:0]       regs [NUM_CSR];

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_entry
    assign hit[g] = (addr == ADDR_LIST[g*12 +: 12]);
    assign state_flat[g*W +: W] = regs[g];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (hit[i]) rd_val = rd_val | regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CSR; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CSR; i++)
        if (hit[i]) regs[i] <= wr_data;
    end
  end
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csr_exec_pkg::*;
#(
  parameter int                    NUM_CSR   = 4,
  parameter logic [NUM_CSR*12-1:0] CSR_ADDRS = {12'h341, 12'h340, 12'h305, 12'h300}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] insn,
  input  logic [31:0] rs1_data,
  output logic        rd_we,
  output logic [4:0]  rd_idx,
  output logic [31:0] rd_data
);
  localparam int STATE_W = NUM_CSR * XLEN;

  acc_dec_t            dec;
  logic [XLEN-1:0]     old_val;
  logic [XLEN-1:0]     operand;
  logic [XLEN-1:0]     new_val;
  logic                store;
  logic                src_nz;
  logic [STATE_W-1:0]  csr_flat;

  csr_decode u_dec (.insn(insn), .dec(dec));

  assign src_nz  = (dec.src != 5'd0);
  assign operand = dec.use_imm ? {{(XLEN-5){1'b0}}, dec.src} : rs1_data;

  csr_update #(.W(XLEN)) u_upd (
    .kind    (dec.kind),
    .src_nz  (src_nz),
    .old_val (old_val),
    .operand (operand),
    .new_val (new_val),
    .store   (store)
  );

  csr_regfile #(.NUM_CSR(NUM_CSR), .W(XLEN), .ADDR_LIST(CSR_ADDRS)) u_file (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (dec.addr),
    .wr_en      (in_valid && dec.legal && store),
    .wr_data    (new_val),
    .rd_val     (old_val),
    .state_flat (csr_flat)
  );

  assign rd_we   = in_valid && dec.legal && (dec.dst != 5'd0);
  assign rd_idx  = dec.dst;
  assign rd_data = old_val;
endmodule

// File: rtl/csr_exec_check.sv
module csr_exec_check #(
  parameter int STATE_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [6:0]         opc,
  input logic [2:0]         f3,
  input logic [4:0]         src,
  input logic               rd_we,
  input logic [4:0]         rd_idx,
  input logic [STATE_W-1:0] csr_flat
);
  logic set_clr_zero;
  assign set_clr_zero = in_valid && (opc == 7'b1110011) && f3[1] && (src == 5'd0);

  a_r9_idle_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !rd_we);

  a_r9_idle_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(csr_flat));

  a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != 5'd0));

  a_r2_foreign_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc != 7'b1110011) |=> $stable(csr_flat));

  a_r2_funct_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (f3[1:0] == 2'b00) |-> !rd_we);

  a_r4_zero_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
    set_clr_zero |=> $stable(csr_flat));
endmodule

bind csr_exec_unit csr_exec_check #(.STATE_W(NUM_CSR*32)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opc      (insn[6:0]),
  .f3       (insn[14:12]),
  .src      (insn[19:15]),
  .rd_we    (rd_we),
  .rd_idx   (rd_idx),
  .csr_flat (csr_flat)
);

// File: tb/test_csr_exec_unit.sv
`timescale 1ns/1ps
module test_csr_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] rs1_data = '0;
  logic        rd_we;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_exec_unit i_csr_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rs1_data(rs1_data), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                     input logic [2:0] f, input logic [4:0] d);
    return {a, s, f, d, 7'b1110011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, check combinational rd port before the edge
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] r,
                      input logic ewe, input logic [31:0] edata, input string tag);
    @(negedge clk);
    in_valid = v; insn = w; rs1_data = r;
    #1;
    chk({tag, " rd_we"}, {31'd0, rd_we}, {31'd0, ewe});
    if (ewe) begin
      chk({tag, " rd_idx"}, {27'd0, rd_idx}, {27'd0, w[11:7]});
      chk({tag, " rd_data"}, rd_data, edata);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // set with source zero reads without writing; junk rs1_data must be ignored
  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string tag);
    step(1'b1, mk(a, 5'd0, 3'b010, 5'd1), 32'hFFFF_FFFF, 1'b1, exp, tag);
  endtask

  task automatic t_reset;
    peek(12'h300, 0, "R1 csr0"); peek(12'h305, 0, "R1 csr1");
    peek(12'h340, 0, "R1 csr2"); peek(12'h341, 0, "R1 csr3");
  endtask

  task automatic t_write;
    step(1'b1, mk(12'h300, 5'd9, 3'b001, 5'd5), 32'hDEAD_BEEF, 1'b1, 0, "R3 R6 write");
    step(1'b1, mk(12'h300, 5'd9, 3'b001, 5'd3), 32'h1234_5678, 1'b1, 32'hDEAD_BEEF, "R10 back-to-back");
    peek(12'h300, 32'h1234_5678, "R3 readback");
  endtask

  task automatic t_set_clear;
    step(1'b1, mk(12'h305, 5'd7, 3'b010, 5'd2), 32'h0000_00F0, 1'b1, 0, "R4 set");
    step(1'b1, mk(12'h305, 5'd7, 3'b011, 5'd2), 32'h0000_0030, 1'b1, 32'h0000_00F0, "R4 clear");
    step(1'b1, mk(12'h305, 5'd0, 3'b011, 5'd2), 32'hFFFF_FFFF, 1'b1, 32'h0000_00C0, "R4 clear idx0");
    peek(12'h305, 32'h0000_00C0, "R4 unchanged");
  endtask

  task automatic t_imm;
    step(1'b1, mk(12'h340, 5'h1F, 3'b101, 5'd4), 32'hFFFF_FFFF, 1'b1, 0, "R5 wi");
    peek(12'h340, 32'h0000_001F, "R5 zero-extend");
    step(1'b1, mk(12'h340, 5'h00, 3'b111, 5'd4), 32'hFFFF_FFFF, 1'b1, 32'h1F, "R5 ci zero");
    step(1'b1, mk(12'h340, 5'h03, 3'b111, 5'd4), 32'hFFFF_FFFF, 1'b1, 32'h1F, "R5 ci");
    step(1'b1, mk(12'h340, 5'h00, 3'b101, 5'd4), 32'hFFFF_FFFF, 1'b1, 32'h1C, "R5 wi zero");
    step(1'b1, mk(12'h340, 5'h05, 3'b110, 5'd4), 32'hFFFF_FFFF, 1'b1, 32'h00, "R5 si");
    peek(12'h340, 32'h0000_0005, "R5 final");
  endtask

  task automatic t_rd_zero;
    step(1'b1, mk(12'h341, 5'd6, 3'b001, 5'd0), 32'hAAAA_5555, 1'b0, 0, "R7 x0");
    peek(12'h341, 32'hAAAA_5555, "R7 still written");
  endtask

  task automatic t_unimpl;
    step(1'b1, mk(12'h7C0, 5'd6, 3'b001, 5'd4), 32'h0BAD_F00D, 1'b1, 0, "R8 write miss");
    peek(12'h7C0, 0, "R8 reads zero");
    peek(12'h300, 32'h1234_5678, "R8 other kept");
  endtask

  task automatic t_foreign;
    step(1'b1, {12'h300, 5'd6, 3'b001, 5'd2, 7'b0010011}, 32'h0, 1'b0, 0, "R2 opcode");
    step(1'b1, mk(12'h300, 5'd6, 3'b000, 5'd2), 32'h0, 1'b0, 0, "R2 f3 000");
    step(1'b1, mk(12'h300, 5'd6, 3'b100, 5'd2), 32'h0, 1'b0, 0, "R2 f3 100");
    peek(12'h300, 32'h1234_5678, "R2 unchanged");
  endtask

  task automatic t_idle;
    step(1'b0, mk(12'h300, 5'd6, 3'b001, 5'd2), 32'h0, 1'b0, 0, "R9 idle");
    peek(12'h300, 32'h1234_5678, "R9 unchanged");
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write();
    t_set_clear();
    t_imm();
    t_rd_zero();
    t_unimpl();
    t_foreign();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule